// File: doc/BRIEF.md
# Framed Byte-Stream Word Rebuilder with Agreement Filter

This block sits behind a byte receiver and rebuilds 32-bit words that a remote sender transmits as short framed packets. A packet opens with the start code 0x74 (ASCII 't'), carries the word as payload bytes (most significant byte first), and closes with the end code 0x78 (ASCII 'x'). Packets come from a slow serial link (9600 baud, one start bit, eight data bits, one stop bit) with a long idle gap between them. Each incoming byte comes with a one-cycle valid strobe.

When the end code arrives, the rebuilt word is put on a raw output with a one-cycle strobe. Single-byte errors on the link are common, so the raw word is not published directly. A short history of recently decoded words is kept. The published word changes only when the newest word equals the word decoded three packets earlier. Otherwise the previous published value stays in place.

Top module: `mframe_word_filter`

## Requirements
- R1: Reset is synchronous and active high. In reset, `word_out` and `raw_word` go to zero, both strobes are low, the filter history is cleared to zero, and the parser waits for a start code. A packet that is only partly received when reset is applied is discarded.
- R2: A byte presented while `rx_valid` is low has no effect on the parser or on any output.
- R3: While the parser is waiting for a start code, every valid byte other than 0x74 is ignored. This includes the end code 0x78, which then produces no `raw_stb`.
- R4: A valid 0x74 clears the accumulator and starts a packet. A 0x74 that arrives inside a packet discards the bytes collected so far and starts the packet again.
- R5: Each payload byte (any valid byte inside a packet other than 0x74 or 0x78) shifts the accumulator left by 8 bits and places the byte in bits 7:0. With four payload bytes, the first byte received lands in bits 31:24 and the last in bits 7:0.
- R6: No payload count is enforced. With more than four payload bytes, only the last four are kept. With fewer than four, the unused upper bytes of the word are zero.
- R7: A valid 0x78 inside a packet loads the accumulator into `raw_word` at that clock edge. `raw_stb` is high for exactly the following cycle, and the parser goes back to waiting for a start code.
- R8: The filter history holds the three most recent raw words. It shifts only on `raw_stb`, and each new raw word is compared with the oldest entry, which is the word from three packets earlier.
- R9: On a match, `word_out` loads the new word at the edge after `raw_stb`, and `word_upd` is high for exactly one cycle. This happens even if the value is unchanged. On a mismatch, `word_out` holds and `word_upd` stays low. `raw_stb` and `word_upd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle qualifier for `rx_byte` |
| raw_word | output | 32 | Most recent word rebuilt from a packet |
| raw_stb | output | 1 | Pulses for one cycle when `raw_word` is loaded |
| word_out | output | 32 | Filtered, published word |
| word_upd | output | 1 | Pulses for one cycle when `word_out` is loaded |

## Verification
The effects of a bad internal state show up at the ports at different speeds:
- **Parser state.** A wrong state shows within one cycle of the next end code: either a `raw_stb` is missing, or one appears for a stray 0x78.
- **Accumulator.** A wrong accumulator shows on `raw_word` at the very strobe that closes the packet.
- **Filter history.** Corruption in the history is the slowest to surface. It appears only up to three packets later, as a missing or extra `word_upd` pulse.

For this reason the stimulus table plays several packets in a row with chosen repeats, so every history slot is compared at least once.

// File: rtl/mframe_pkg.sv
package mframe_pkg;

    localparam int unsigned DEF_BYTE_W     = 8;
    localparam int unsigned DEF_WORD_W     = 32;
    localparam int unsigned DEF_HIST_DEPTH = 3;
    localparam logic [7:0]  DEF_OPEN_CODE  = 8'h74;
    localparam logic [7:0]  DEF_CLOSE_CODE = 8'h78;

    typedef enum logic [0:0] {
        PS_HUNT    = 1'b0,
        PS_COLLECT = 1'b1
    } parse_state_t;

    typedef enum logic [1:0] {
        BK_IGNORE,
        BK_OPEN,
        BK_CLOSE,
        BK_DATA
    } byte_kind_t;

    function automatic byte_kind_t classify(
        input logic [7:0] b,
        input logic       vld,
        input logic [7:0] open_code,
        input logic [7:0] close_code
    );
        if (!vld)                 return BK_IGNORE;
        else if (b == open_code)  return BK_OPEN;
        else if (b == close_code) return BK_CLOSE;
        else                      return BK_DATA;
    endfunction

endpackage

// File: rtl/mframe_parser.sv
module mframe_parser
    import mframe_pkg::*;
#(
    parameter int unsigned BYTE_W     = DEF_BYTE_W,
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter logic [7:0]  OPEN_CODE  = DEF_OPEN_CODE,
    parameter logic [7:0]  CLOSE_CODE = DEF_CLOSE_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_vld,
    output logic [WORD_W-1:0] out_word,
    output logic              out_stb
);
    localparam int unsigned KEEP_W = WORD_W - BYTE_W;

    parse_state_t       st;
    logic [WORD_W-1:0]  acc;
    byte_kind_t         kind;

    always_comb kind = classify(in_byte, in_vld, OPEN_CODE, CLOSE_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_HUNT;
            acc      <= '0;
            out_word <= '0;
            out_stb  <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            unique case (st)
                PS_HUNT: begin
                    if (kind == BK_OPEN) begin
                        st  <= PS_COLLECT;
                        acc <= '0;
                    end
                end
                PS_COLLECT: begin
                    unique case (kind)
                        BK_OPEN:  acc <= '0;
                        BK_CLOSE: begin
                            out_word <= acc;
                            out_stb  <= 1'b1;
                            st       <= PS_HUNT;
                        end
                        BK_DATA:  acc <= {acc[KEEP_W-1:0], in_byte};
                        default:  acc <= acc;
                    endcase
                end
                default: st <= PS_HUNT;
            endcase
        end
    end

    // R7: a raw strobe is always caused by a valid close code in the previous cycle
    assert_raw_from_close_R7: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> ($past(in_vld) && $past(in_byte) == CLOSE_CODE));

    // R2: an idle input cycle leaves parser state and accumulator untouched
    assert_idle_no_effect_R2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(st) && $stable(acc) && !out_stb));

    // R3: while hunting, a non-open byte keeps the parser hunting with no strobe
    assert_hunt_ignores_R3: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HUNT && in_vld && in_byte != OPEN_CODE) |=> (st == PS_HUNT && !out_stb));

    // R4: an open code always leaves an empty accumulator in collect state
    assert_open_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_byte == OPEN_CODE) |=> (st == PS_COLLECT && acc == '0));

    // R5: a payload byte lands in the low byte of the accumulator
    assert_payload_low_R5: assert property (@(posedge clk) disable iff (rst)
        (st == PS_COLLECT && in_vld && in_byte != OPEN_CODE && in_byte != CLOSE_CODE)
        |=> (acc[BYTE_W-1:0] == $past(in_byte)));

endmodule

// File: rtl/mframe_filter.sv
module mframe_filter
    import mframe_pkg::*;
#(
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned HIST_DEPTH = DEF_HIST_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] new_word,
    input  logic              new_stb,
    output logic [WORD_W-1:0] pub_word,
    output logic              pub_stb
);
    localparam int unsigned OLDEST = HIST_DEPTH - 1;

    logic [HIST_DEPTH-1:0][WORD_W-1:0] hist;
    logic                              agree;

    always_comb agree = (new_word == hist[OLDEST]);

    generate
        for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist[g] <= '0;
                end else if (new_stb) begin
                    if (g == 0) hist[g] <= new_word;
                    else        hist[g] <= hist[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pub_word <= '0;
            pub_stb  <= 1'b0;
        end else begin
            pub_stb <= 1'b0;
            if (new_stb && agree) begin
                pub_word <= new_word;
                pub_stb  <= 1'b1;
            end
        end
    end

    // R8: history moves only on a completed packet
    assert_hist_still_R8: assert property (@(posedge clk) disable iff (rst)
        !new_stb |=> $stable(hist[OLDEST]));

    // R9: a publish pulse follows a raw strobe and carries that raw word
    assert_upd_after_raw_R9: assert property (@(posedge clk) disable iff (rst)
        pub_stb |-> ($past(new_stb) && pub_word == $past(new_word)));

    // R9: without a publish pulse the published word holds
    assert_pub_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !pub_stb |-> $stable(pub_word));

endmodule

// File: rtl/mframe_word_filter.sv
module mframe_word_filter
    import mframe_pkg::*;
#(
    parameter int unsigned BYTE_W     = DEF_BYTE_W,
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned HIST_DEPTH = DEF_HIST_DEPTH,
    parameter logic [7:0]  OPEN_CODE  = DEF_OPEN_CODE,
    parameter logic [7:0]  CLOSE_CODE = DEF_CLOSE_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [WORD_W-1:0] raw_word,
    output logic              raw_stb,
    output logic [WORD_W-1:0] word_out,
    output logic              word_upd
);
    mframe_parser #(
        .BYTE_W    (BYTE_W),
        .WORD_W    (WORD_W),
        .OPEN_CODE (OPEN_CODE),
        .CLOSE_CODE(CLOSE_CODE)
    ) u_parse (
        .clk     (clk),
        .rst     (rst),
        .in_byte (rx_byte),
        .in_vld  (rx_valid),
        .out_word(raw_word),
        .out_stb (raw_stb)
    );

    mframe_filter #(
        .WORD_W    (WORD_W),
        .HIST_DEPTH(HIST_DEPTH)
    ) u_filt (
        .clk     (clk),
        .rst     (rst),
        .new_word(raw_word),
        .new_stb (raw_stb),
        .pub_word(word_out),
        .pub_stb (word_upd)
    );

    // R9: raw and publish strobes never coincide
    assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({raw_stb, word_upd}));

endmodule

// File: tb/sim_mframe_word_filter.sv
module sim_mframe_word_filter;
    localparam logic [7:0] OPN = 8'h74;
    localparam logic [7:0] CLS = 8'h78;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic [31:0] raw_word, word_out;
    logic        raw_stb, word_upd;

    int total = 0;
    int fails = 0;
    int raw_cnt = 0;
    int upd_cnt = 0;
    logic [31:0] last_raw = '0;
    bit done = 0;

    always #5 clk = ~clk;

    mframe_word_filter u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .raw_word(raw_word), .raw_stb(raw_stb),
        .word_out(word_out), .word_upd(word_upd)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (raw_stb) begin raw_cnt++; last_raw = raw_word; end
            if (word_upd) upd_cnt++;
        end
    end

    // {sent word, expected published word, expected update pulse}
    localparam logic [64:0] VEC [8] = '{
        {32'h12345679, 32'h00000000, 1'b0},
        {32'hCAFEF00D, 32'h00000000, 1'b0},
        {32'h00000000, 32'h00000000, 1'b1},
        {32'h12345679, 32'h12345679, 1'b1},
        {32'hDEADBEEF, 32'h12345679, 1'b0},
        {32'hCAFEF00D, 32'h12345679, 1'b0},
        {32'h12345679, 32'h12345679, 1'b1},
        {32'hDEADBEEF, 32'hDEADBEEF, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_byte  = 8'h00;
        end
        #1;
    endtask

    task automatic send_frame(input logic [31:0] w);
        put(OPN);
        for (int i = 3; i >= 0; i--) put(w[i*8 +: 8]);
        put(CLS);
        idle(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r0, u0c;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 word_out", word_out, 32'h0);
        check("R1 raw_word", raw_word, 32'h0);
        check("R1 strobes", {30'h0, raw_stb, word_upd}, 32'h0);

        // R5, R7, R8, R9: table walk
        for (int k = 0; k < 8; k++) begin
            r0 = raw_cnt; u0c = upd_cnt;
            send_frame(VEC[k][64:33]);
            check("R7 raw strobe count", raw_cnt - r0, 1);
            check("R5 raw word", last_raw, VEC[k][64:33]);
            check("R8/R9 update pulse", upd_cnt - u0c, {31'h0, VEC[k][0]});
            check("R9 published word", word_out, VEC[k][32:1]);
        end

        // R3: noise and close code while hunting produce nothing
        r0 = raw_cnt;
        put(8'h55); put(CLS); put(8'h11); put(CLS); idle(4);
        check("R3 no strobe while hunting", raw_cnt - r0, 0);
        check("R3 raw unchanged", raw_word, 32'hDEADBEEF);

        // R4: restart inside a packet
        r0 = raw_cnt;
        put(OPN); put(8'hAA); put(8'hBB); put(OPN);
        put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(CLS); idle(4);
        check("R4 restart strobe", raw_cnt - r0, 1);
        check("R4 restart word", last_raw, 32'h01020304);

        // R6: short, long and empty packets
        put(OPN); put(8'h9A); put(CLS); idle(4);
        check("R6 short word", last_raw, 32'h0000009A);
        put(OPN); put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h05); put(CLS); idle(4);
        check("R6 long word", last_raw, 32'h02030405);
        put(OPN); put(CLS); idle(4);
        check("R6 empty word", last_raw, 32'h00000000);

        // R2: invalid cycles carrying marker and data values are ignored
        r0 = raw_cnt;
        put(OPN); put(8'h21);
        @(negedge clk); rx_valid = 1'b0; rx_byte = CLS;
        @(negedge clk); rx_valid = 1'b0; rx_byte = OPN;
        @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h99;
        put(8'h43); put(8'h65); put(8'h87); put(CLS); idle(4);
        check("R2 single strobe", raw_cnt - r0, 1);
        check("R2 word intact", last_raw, 32'h21436587);

        // R1: reset mid-packet discards it and clears the published word
        put(OPN); put(8'h11);
        @(negedge clk); rx_valid = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 word_out after reset", word_out, 32'h0);
        r0 = raw_cnt;
        put(8'h22); put(CLS); idle(4);
        check("R1 partial packet dropped", raw_cnt - r0, 0);

        // R8: history cleared by reset, zero word matches at once
        u0c = upd_cnt;
        send_frame(32'h00000000);
        check("R8 zero matches cleared history", upd_cnt - u0c, 1);
        u0c = upd_cnt;
        send_frame(32'h0BADF00D);
        check("R9 mismatch no pulse", upd_cnt - u0c, 0);
        check("R9 mismatch holds", word_out, 32'h0);

        finish_run();
    end
endmodule